// File: doc/BRIEF.md
# Programmed-I/O Command Sequencer

This block runs one software-initiated transaction against a downstream bus engine. Software fills a small register file with a byte count, a 24-bit target address and up to sixteen 32-bit data words. It then writes the control register with an operation code and the go bit. The sequencer hands a command to the engine, streams the write words, collects the read words back into the same data buffer, and raises a sticky completion flag. If the interrupt enable is set, the flag also drives the interrupt.

Three operations are supported: write, read, and write followed by read. In the last one, the write phase takes the low words of the buffer and the read phase then overwrites the buffer starting at word 0. While a cycle runs, the control, count, address and data registers are frozen. Any attempt to change them is dropped and recorded as a sequence error. A go request whose byte count exceeds the buffer is also recorded as a sequence error, and no cycle starts.

Top module: `pio_seq`

## Requirements
- R1: After reset, status (word 1) reads 0, control (word 0) reads 0, `irq_o` is 0 and no handshake valid or ready output is asserted.
- R2: Writing control with bit 0 = 1, op in bits [2:1] (01 write, 10 read, 11 write-then-read) and valid counts asserts `cmd_valid_o` on the next cycle. The command carries the op, the target address (word 3, bits [23:0]), the write byte count (word 2, bits [6:0]) and the read byte count (word 2, bits [22:16]).
- R3: For ops with a write phase, ceil(write count / 4) words are sent on the write channel, from data word 0 (register word 16) upward in order. At most one of `cmd_valid_o`, `wr_valid_o` and `rd_ready_o` is high at a time.
- R4: For a read, ceil(read count / 4) returned words land in data words 0 upward. Data words beyond that keep their values.
- R5: In write-then-read, the write phase finishes with the data as programmed. Only then are the read words stored from data word 0.
- R6: When the cycle ends, status bit 0 (done) is set, status bit 2 (busy) and control bit 0 read 0.
- R7: `irq_o` is high exactly while done is set and control bit 3 (interrupt enable) is 1.
- R8: Writing 1 to status bit 0 or bit 1 clears done or sequence error. Clearing done also drops `irq_o`.
- R9: While busy, writes to control, count, address or data registers have no effect (including a second go), and they set status bit 1 (sequence error).
- R10: A go with op 00, or with a byte count above 64 in an active phase, sets the sequence error and starts no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Completion interrupt |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by engine |
| cmd_op_o | output | 2 | Operation code |
| cmd_taddr_o | output | 24 | Target address |
| cmd_wcnt_o | output | 7 | Write byte count |
| cmd_rcnt_o | output | 7 | Read byte count |
| wr_valid_o | output | 1 | Write word valid |
| wr_ready_i | input | 1 | Write word accepted |
| wr_data_o | output | 32 | Write word |
| rd_valid_i | input | 1 | Read word valid |
| rd_ready_o | output | 1 | Sequencer accepting read words |
| rd_data_i | input | 32 | Read word |

## Verification
The hardest case to reach is a register write that lands while a cycle is still in flight. The engine model accepts commands and words at once, so a cycle lasts only a few clocks. The directed lock test therefore starts a two-word read and issues an address write, a data write and a second go on the three clock edges that follow. After completion it reads back the address and the untouched data word. The write-then-read rows of the vector table check that the captured write stream still holds the programmed words while the buffer afterwards holds the read pattern.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_WRRD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CMD,
    S_WR,
    S_RD
  } st_e;

  localparam int unsigned RA_CTRL  = 0;
  localparam int unsigned RA_STAT  = 1;
  localparam int unsigned RA_BCNT  = 2;
  localparam int unsigned RA_TADDR = 3;
  localparam int unsigned RCNT_LSB = 16;
endpackage

// File: rtl/pio_seq_regs.sv
module pio_seq_regs
  import pio_seq_pkg::*;
#(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned TAW    = 24,
  parameter int unsigned AW     = $clog2(NWORDS) + 1,
  parameter int unsigned CW     = $clog2(NWORDS * 4 + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           busy_i,
  input  logic           fin_i,
  input  logic           buf_we_i,
  input  logic [$clog2(NWORDS)-1:0] buf_idx_i,
  input  logic [DW-1:0]  buf_wdata_i,
  output logic [DW-1:0]  buf_rdata_o,
  output logic           start_o,
  output op_e            op_o,
  output logic [CW-1:0]  wcnt_o,
  output logic [CW-1:0]  rcnt_o,
  output logic [TAW-1:0] taddr_o,
  output logic           irq_en_o,
  output logic           done_o,
  output logic           err_o,
  output logic           irq_o
);
  localparam int unsigned IW   = $clog2(NWORDS);
  localparam int unsigned MAXB = NWORDS * 4;

  logic [DW-1:0]  data_q [NWORDS];
  op_e            op_q;
  logic           irq_en_q, done_q, err_q;
  logic [CW-1:0]  wcnt_q, rcnt_q;
  logic [TAW-1:0] taddr_q;

  logic is_data, a_ctrl, a_stat, a_bcnt, a_taddr;
  logic lock_hit, go_req, cnt_ok, upd;
  op_e  new_op;

  assign is_data = addr_i[AW-1];
  assign a_ctrl  = !is_data && (addr_i == AW'(RA_CTRL));
  assign a_stat  = !is_data && (addr_i == AW'(RA_STAT));
  assign a_bcnt  = !is_data && (addr_i == AW'(RA_BCNT));
  assign a_taddr = !is_data && (addr_i == AW'(RA_TADDR));

  assign lock_hit = we_i && (is_data || a_ctrl || a_bcnt || a_taddr);
  assign upd      = !busy_i;
  assign new_op   = op_e'(wdata_i[2:1]);
  assign go_req   = we_i && a_ctrl && wdata_i[0] && !busy_i;

  always_comb begin
    cnt_ok = (new_op != OP_NONE);
    if (new_op[0] && (wcnt_q > CW'(MAXB))) cnt_ok = 1'b0;
    if (new_op[1] && (rcnt_q > CW'(MAXB))) cnt_ok = 1'b0;
  end

  assign start_o = go_req && cnt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_NONE;
      irq_en_q <= 1'b0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
      taddr_q  <= '0;
    end else if (we_i && upd) begin
      if (a_ctrl) begin
        op_q     <= new_op;
        irq_en_q <= wdata_i[3];
      end
      if (a_bcnt) begin
        wcnt_q <= wdata_i[CW-1:0];
        rcnt_q <= wdata_i[RCNT_LSB+CW-1:RCNT_LSB];
      end
      if (a_taddr) taddr_q <= wdata_i[TAW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
    end else if (buf_we_i) begin
      data_q[buf_idx_i] <= buf_wdata_i;
    end else if (we_i && upd && is_data) begin
      data_q[addr_i[IW-1:0]] <= wdata_i;
    end
  end

  // set wins over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (fin_i)                            done_q <= 1'b1;
      else if (we_i && a_stat && wdata_i[0]) done_q <= 1'b0;
      if ((lock_hit && busy_i) || (go_req && !cnt_ok)) err_q <= 1'b1;
      else if (we_i && a_stat && wdata_i[1])          err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_data) rdata_o = data_q[addr_i[IW-1:0]];
    else if (a_ctrl)  rdata_o = DW'({irq_en_q, op_q, busy_i});
    else if (a_stat)  rdata_o = DW'({busy_i, err_q, done_q});
    else if (a_bcnt) begin
      rdata_o[CW-1:0]                 = wcnt_q;
      rdata_o[RCNT_LSB+CW-1:RCNT_LSB] = rcnt_q;
    end else if (a_taddr) rdata_o = DW'(taddr_q);
  end

  assign buf_rdata_o = data_q[buf_idx_i];
  assign op_o        = op_q;
  assign wcnt_o      = wcnt_q;
  assign rcnt_o      = rcnt_q;
  assign taddr_o     = taddr_q;
  assign irq_en_o    = irq_en_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign irq_o       = done_q && irq_en_q;
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_seq_pkg::*;
#(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = $clog2(NWORDS * 4 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [CW-1:0] wcnt_i,
  input  logic [CW-1:0] rcnt_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  input  logic          rd_valid_i,
  output logic          rd_ready_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [$clog2(NWORDS)-1:0] buf_idx_o,
  output logic          buf_we_o,
  output logic [DW-1:0] buf_wdata_o
);
  localparam int unsigned IW = $clog2(NWORDS);

  st_e           st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] wwords, rwords;
  logic          has_wr, has_rd;

  assign wwords = CW'((({1'b0, wcnt_i}) + (CW + 1)'(3)) >> 2);
  assign rwords = CW'((({1'b0, rcnt_i}) + (CW + 1)'(3)) >> 2);
  assign has_wr = op_i[0] && (wwords != '0);
  assign has_rd = op_i[1] && (rwords != '0);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    fin_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d  = S_CMD;
        idx_d = '0;
      end
      S_CMD: if (cmd_ready_i) begin
        if (has_wr)      st_d = S_WR;
        else if (has_rd) st_d = S_RD;
        else begin
          st_d  = S_IDLE;
          fin_o = 1'b1;
        end
      end
      S_WR: if (wr_ready_i) begin
        if (idx_q == wwords - 1'b1) begin
          idx_d = '0;
          if (has_rd) st_d = S_RD;
          else begin
            st_d  = S_IDLE;
            fin_o = 1'b1;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_RD: if (rd_valid_i) begin
        if (idx_q == rwords - 1'b1) begin
          idx_d = '0;
          st_d  = S_IDLE;
          fin_o = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign cmd_valid_o = (st_q == S_CMD);
  assign wr_valid_o  = (st_q == S_WR);
  assign rd_ready_o  = (st_q == S_RD);
  assign buf_idx_o   = idx_q[IW-1:0];
  assign buf_we_o    = (st_q == S_RD) && rd_valid_i;
  assign buf_wdata_o = rd_data_i;
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned TAW    = 24,
  parameter int unsigned AW     = $clog2(NWORDS) + 1,
  parameter int unsigned CW     = $clog2(NWORDS * 4 + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           irq_o,
  output logic           cmd_valid_o,
  input  logic           cmd_ready_i,
  output logic [1:0]     cmd_op_o,
  output logic [TAW-1:0] cmd_taddr_o,
  output logic [CW-1:0]  cmd_wcnt_o,
  output logic [CW-1:0]  cmd_rcnt_o,
  output logic           wr_valid_o,
  input  logic           wr_ready_i,
  output logic [DW-1:0]  wr_data_o,
  input  logic           rd_valid_i,
  output logic           rd_ready_o,
  input  logic [DW-1:0]  rd_data_i
);
  localparam int unsigned IW = $clog2(NWORDS);

  logic           start_w, busy_w, fin_w, done_w, err_w, irq_en_w;
  logic           buf_we_w;
  logic [IW-1:0]  buf_idx_w;
  logic [DW-1:0]  buf_wdata_w, buf_rdata_w;
  op_e            op_w;
  logic [CW-1:0]  wcnt_w, rcnt_w;
  logic [TAW-1:0] taddr_w;

  pio_seq_regs #(
    .NWORDS(NWORDS), .DW(DW), .TAW(TAW), .AW(AW), .CW(CW)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy_w),
    .fin_i       (fin_w),
    .buf_we_i    (buf_we_w),
    .buf_idx_i   (buf_idx_w),
    .buf_wdata_i (buf_wdata_w),
    .buf_rdata_o (buf_rdata_w),
    .start_o     (start_w),
    .op_o        (op_w),
    .wcnt_o      (wcnt_w),
    .rcnt_o      (rcnt_w),
    .taddr_o     (taddr_w),
    .irq_en_o    (irq_en_w),
    .done_o      (done_w),
    .err_o       (err_w),
    .irq_o       (irq_o)
  );

  pio_seq_fsm #(
    .NWORDS(NWORDS), .DW(DW), .CW(CW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .op_i        (op_w),
    .wcnt_i      (wcnt_w),
    .rcnt_i      (rcnt_w),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .rd_valid_i  (rd_valid_i),
    .rd_ready_o  (rd_ready_o),
    .rd_data_i   (rd_data_i),
    .busy_o      (busy_w),
    .fin_o       (fin_w),
    .buf_idx_o   (buf_idx_w),
    .buf_we_o    (buf_we_w),
    .buf_wdata_o (buf_wdata_w)
  );

  assign cmd_op_o    = op_w;
  assign cmd_taddr_o = taddr_w;
  assign cmd_wcnt_o  = wcnt_w;
  assign cmd_rcnt_o  = rcnt_w;
  assign wr_data_o   = buf_rdata_w;
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 5,
  parameter int unsigned CW     = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic          irq_o,
  input logic          cmd_valid_o,
  input logic          wr_valid_o,
  input logic          rd_ready_o,
  input logic          start_w,
  input logic          busy_w,
  input logic          fin_w,
  input logic          done_w,
  input logic          err_w,
  input logic          irq_en_w,
  input logic [CW-1:0] wcnt_w,
  input logic [CW-1:0] rcnt_w
);
  localparam int unsigned MAXB = NWORDS * 4;

  logic       lock_try, go_try, go_bad;
  logic [1:0] go_op;

  assign lock_try = reg_we_i && (reg_addr_i[AW-1] || reg_addr_i == AW'(0) ||
                                 reg_addr_i == AW'(2) || reg_addr_i == AW'(3));
  assign go_op    = reg_wdata_i[2:1];
  assign go_try   = reg_we_i && reg_addr_i == AW'(0) && reg_wdata_i[0] && !busy_w;
  assign go_bad   = (go_op == 2'b00) || (go_op[0] && wcnt_w > CW'(MAXB)) ||
                    (go_op[1] && rcnt_w > CW'(MAXB));

  p_cmd_after_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> cmd_valid_o);

  p_one_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, wr_valid_o, rd_ready_o}));

  p_fin_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_w |=> (!busy_w && done_w));

  p_irq_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_w && irq_en_w) |=> irq_o);

  p_lock_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && lock_try) |=> err_w);

  p_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_try && go_bad) |=> (err_w && !busy_w));
endmodule

bind pio_seq pio_seq_chk #(
  .NWORDS(NWORDS), .DW(DW), .AW(AW), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .cmd_valid_o (cmd_valid_o),
  .wr_valid_o  (wr_valid_o),
  .rd_ready_o  (rd_ready_o),
  .start_w     (start_w),
  .busy_w      (busy_w),
  .fin_w       (fin_w),
  .done_w      (done_w),
  .err_w       (err_w),
  .irq_en_w    (irq_en_w),
  .wcnt_w      (wcnt_w),
  .rcnt_w      (rcnt_w)
);

// File: tb/tb_pio_seq.sv
module tb_pio_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 11;
  localparam logic [4:0] A_CTRL = 5'd0, A_STAT = 5'd1, A_BCNT = 5'd2, A_TADDR = 5'd3, A_DATA = 5'd16;

  // {irq_en, op, wcnt, rcnt, taddr, bad}
  localparam logic [43:0] VEC [NROWS] = '{
    {1'b0, 2'd1, 8'd4,  8'd0,  24'h000100, 1'b0},
    {1'b1, 2'd1, 8'd64, 8'd0,  24'h0A0B0C, 1'b0},
    {1'b0, 2'd1, 8'd5,  8'd0,  24'h123456, 1'b0},
    {1'b1, 2'd2, 8'd0,  8'd8,  24'h00FF00, 1'b0},
    {1'b0, 2'd2, 8'd0,  8'd3,  24'h000001, 1'b0},
    {1'b1, 2'd3, 8'd6,  8'd12, 24'h222222, 1'b0},
    {1'b0, 2'd3, 8'd64, 8'd64, 24'h3F3F3F, 1'b0},
    {1'b0, 2'd1, 8'd65, 8'd0,  24'h000010, 1'b1},
    {1'b0, 2'd2, 8'd0,  8'd70, 24'h000020, 1'b1},
    {1'b0, 2'd0, 8'd4,  8'd0,  24'h000030, 1'b1},
    {1'b1, 2'd2, 8'd0,  8'd64, 24'hABCDEF, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, cmd_valid, wr_valid, rd_ready;
  logic [1:0]  cmd_op;
  logic [23:0] cmd_taddr;
  logic [6:0]  cmd_wcnt, cmd_rcnt;
  logic [31:0] wr_data, rd_data = '0;

  int          n_chk = 0, n_fail = 0;
  int          ncmd = 0, wcount = 0, rcount = 0;
  logic [1:0]  cap_op;
  logic [23:0] cap_ta;
  logic [6:0]  cap_wc, cap_rc;
  logic [31:0] cap_w [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pio_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(1'b1), .cmd_op_o(cmd_op), .cmd_taddr_o(cmd_taddr),
    .cmd_wcnt_o(cmd_wcnt), .cmd_rcnt_o(cmd_rcnt),
    .wr_valid_o(wr_valid), .wr_ready_i(1'b1), .wr_data_o(wr_data),
    .rd_valid_i(1'b1), .rd_ready_o(rd_ready), .rd_data_i(rd_data)
  );

  function automatic logic [31:0] rpat(logic [23:0] ta, int i);
    return 32'h5A5A0000 ^ {ta[15:0], 16'(i)};
  endfunction

  function automatic logic [31:0] dpat(int r, int i);
    return 32'hD0000000 | (r << 16) | i;
  endfunction

  // engine model: always ready; transfers decided from handshake state before each edge
  always @(negedge clk) begin
    if (cmd_valid) begin
      cap_op = cmd_op; cap_ta = cmd_taddr; cap_wc = cmd_wcnt; cap_rc = cmd_rcnt;
      ncmd++; wcount = 0; rcount = 0;
    end
    if (wr_valid) begin
      if (wcount < 16) cap_w[wcount] = wr_data;
      wcount++;
    end
    rd_data = rpat(cap_ta, rcount);
    if (rd_ready) rcount++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      rd(A_STAT, s);
      if (s[0]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit          ok;
    int          n0;

    // R1: reset state
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
    rd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
    chk({irq, cmd_valid, wr_valid, rd_ready} == 0, "R1 outputs", {irq, cmd_valid, wr_valid, rd_ready}, 0);

    for (int r = 0; r < NROWS; r++) begin
      logic        irqen, bad;
      logic [1:0]  op;
      logic [7:0]  wc, rc;
      logic [23:0] ta;
      int          ww, rw, wrong;
      {irqen, op, wc, rc, ta, bad} = VEC[r];
      ww = op[0] ? (int'(wc) + 3) / 4 : 0;
      rw = op[1] ? (int'(rc) + 3) / 4 : 0;
      for (int i = 0; i < 16; i++) wr(A_DATA + 5'(i), dpat(r, i));
      wr(A_BCNT, {8'd0, rc, 8'd0, wc});
      wr(A_TADDR, {8'd0, ta});
      n0 = ncmd;
      wr(A_CTRL, {28'd0, irqen, op, 1'b1});
      if (bad) begin
        rd(A_STAT, v); chk(v == 32'h2, "R10 reject status", v, 32'h2);
        chk(ncmd == n0, "R10 no command", ncmd, n0);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk(v == 0, "R8 clear err", v, 0);
      end else begin
        wait_done(ok);
        chk(ok, "R6 done seen", 32'(ok), 1);
        chk(ncmd == n0 + 1, "R2 one command", ncmd, n0 + 1);
        chk({cap_op, cap_ta, cap_wc, cap_rc} == {op, ta, wc[6:0], rc[6:0]}, "R2 command fields",
            {cap_op, cap_ta[5:0], cap_wc, cap_rc, 3'b0}, {op, ta[5:0], wc[6:0], rc[6:0], 3'b0});
        chk(wcount == ww, "R3 write word count", wcount, ww);
        wrong = 0;
        for (int i = 0; i < ww && i < 16; i++) if (cap_w[i] != dpat(r, i)) wrong++;
        chk(wrong == 0, (op == 2'd3) ? "R5 write phase data" : "R3 write data order", wrong, 0);
        chk(rcount == rw, "R4 read word count", rcount, rw);
        wrong = 0;
        for (int i = 0; i < 16; i++) begin
          rd(A_DATA + 5'(i), v);
          if (v != ((i < rw) ? rpat(ta, i) : dpat(r, i))) wrong++;
        end
        chk(wrong == 0, (op == 2'd3) ? "R5 buffer after read" : "R4 buffer contents", wrong, 0);
        rd(A_CTRL, v); chk(v[0] == 1'b0, "R6 go self-clear", v, {v[31:1], 1'b0});
        rd(A_STAT, v); chk(v == 32'h1, "R6 status done", v, 32'h1);
        chk(irq == irqen, "R7 irq follows enable", irq, irqen);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk(v == 0, "R8 clear done", v, 0);
        chk(irq == 1'b0, "R8 irq drops", irq, 0);
      end
    end

    // R9: register lock while a two-word read runs
    wr(A_DATA + 5'd10, 32'hCAFE0010);
    wr(A_BCNT, {8'd0, 8'd8, 8'd0, 8'd0});
    wr(A_TADDR, 32'h000777);
    n0 = ncmd;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = {28'd0, 1'b0, 2'd2, 1'b1};
    @(negedge clk);
    reg_addr = A_TADDR; reg_wdata = 32'h000999;
    @(negedge clk);
    reg_addr = A_DATA + 5'd10; reg_wdata = 32'h0BAD0BAD;
    @(negedge clk);
    reg_addr = A_CTRL; reg_wdata = {28'd0, 1'b0, 2'd1, 1'b1};
    @(negedge clk);
    reg_we = 1'b0;
    wait_done(ok);
    repeat (3) @(negedge clk);
    chk(ncmd == n0 + 1, "R9 second go ignored", ncmd, n0 + 1);
    chk(cap_ta == 24'h000777, "R9 command address", cap_ta, 24'h000777);
    rd(A_TADDR, v); chk(v == 32'h000777, "R9 address kept", v, 32'h000777);
    rd(A_DATA + 5'd10, v); chk(v == 32'hCAFE0010, "R9 data kept", v, 32'hCAFE0010);
    rd(A_CTRL, v); chk(v[2:1] == 2'd2, "R9 op kept", v[2:1], 2'd2);
    rd(A_STAT, v); chk(v == 32'h3, "R9 seq error and done", v, 32'h3);
    wr(A_STAT, 32'h3);
    rd(A_STAT, v); chk(v == 0, "R8 clear both", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule